// File: doc/BRIEF.md
# Byte-Wise Convolutional De-Interleaver

This block reverses a twelve-branch convolutional byte interleave applied to a stream that is framed in 204-byte packets. The first byte of each packet is a sync byte, and an upstream stage marks it with a start flag. Each accepted byte is written into one of twelve delay lines. The line chosen for the flagged sync byte holds it longest, and the choice moves on by one line for each further valid byte, wrapping after the twelfth. Line `j` holds its bytes for `(11-j)*17` of its own accesses. Every byte therefore leaves the block exactly eleven packets (2244 bytes) after its matching byte entered the interleaver. The 204-byte sync spacing is the same on both sides of the block.

A run-time bypass input turns de-interleaving off. In bypass the block returns its input one cycle later, with the valid and start flags unchanged, and it leaves the delay lines, the branch selector and the packet counter untouched. The delay lines are written as read-before-write memories, so block RAM can be inferred for them. The output start flag is rebuilt from a byte counter that runs modulo 204 and is cleared on each input start flag.

Top module: `cdil_deinterleaver`

## Requirements
- R1: With bypass low and a correctly interleaved input, once 2244 bytes have come out, output byte number k (counted over valid output bytes) equals source byte k-2244. The branch used for a flagged start byte is branch 0, the one with the longest delay, `11*17` accesses. Each later valid byte uses the next branch, modulo 12. Branch j delays by `(11-j)*17` accesses.
- R2: With bypass low, `out_sop` is high on every output byte whose index is a multiple of 204 and on no other byte, and that byte carries the sync value 0x47.
- R3: With bypass low, `out_valid` equals `in_valid` from two clock cycles earlier, so gaps in the input are kept in the output.
- R4: With bypass high, `out_valid`, `out_sop` and `out_data` equal `in_valid`, `in_valid & in_sop` and `in_data` from one cycle earlier. Bypass may change only after at least two idle input cycles.
- R5: Bytes accepted while bypass is high change no de-interleaver state. When bypass returns low, the stream resumes with R1 and R2 still holding.
- R6: While reset is high and in the first cycle after it, `out_valid` and `out_sop` are low.
- R7: `out_sop` is never high unless `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | Input byte is a packet sync byte |
| in_data | input | DATA_W | Input byte |
| bypass | input | 1 | 1: pass input through, 0: de-interleave |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | Output byte is a packet start |
| out_data | output | DATA_W | Output byte |

## Verification
In de-interleave mode a byte passes through two register stages: the memory read and then the output register. Its valid pulse is therefore due two cycles after the input was taken. In bypass it is due one cycle later. The bench samples on the falling edge and keeps a short history of the inputs it drove, so each cycle's `out_valid` is compared against the input from exactly one or two cycles earlier. Content is checked by position in the output stream rather than by cycle: valid output byte k must equal source byte k-2244, found by a bench-side interleaver model. No checks run during the idle cycles around a bypass change.

// File: rtl/cdil_pkg.sv
package cdil_pkg;
  localparam int unsigned BYTE_W = 8;

  // Delay of one de-interleaver branch, counted in accesses to that branch.
  function automatic int unsigned branch_depth(input int unsigned idx,
                                               input int unsigned n_br,
                                               input int unsigned unit);
    return (n_br - 1 - idx) * unit;
  endfunction
endpackage

// File: rtl/cdil_branch.sv
module cdil_branch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data
);
  generate
    if (DEPTH == 0) begin : g_wire
      always_ff @(posedge clk) begin
        if (wr_en) rd_data <= din;
      end
    end else begin : g_ram
      localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
      logic [DATA_W-1:0] mem [DEPTH];
      logic [PW-1:0]     ptr_q;

      // Read-before-write on a single address: block RAM friendly.
      always_ff @(posedge clk) begin
        if (wr_en) begin
          rd_data    <= mem[ptr_q];
          mem[ptr_q] <= din;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else if (wr_en) ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end

      AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(ptr_q) < DEPTH); // R1
    end
  endgenerate
endmodule

// File: rtl/cdil_sequencer.sv
module cdil_sequencer #(
  parameter int unsigned BRANCHES = 12,
  parameter int unsigned PKT_LEN  = 204
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic                        sop,
  output logic [$clog2(BRANCHES)-1:0] cur_branch,
  output logic                        head
);
  localparam int unsigned BW = $clog2(BRANCHES);
  localparam int unsigned CW = $clog2(PKT_LEN);

  logic [BW-1:0] sel_q;
  logic [CW-1:0] pos_q;
  logic [CW-1:0] cur_pos;
  logic          locked_q;

  always_comb begin
    cur_branch = sop ? '0 : sel_q;
    cur_pos    = sop ? '0 : pos_q;
    head       = (cur_pos == '0) && (sop || locked_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else if (adv) begin
      sel_q    <= (cur_branch == BW'(BRANCHES - 1)) ? '0 : cur_branch + 1'b1;
      pos_q    <= (cur_pos == CW'(PKT_LEN - 1)) ? '0 : cur_pos + 1'b1;
      if (sop) locked_q <= 1'b1;
    end
  end

  AST_HEAD_BRANCH0: assert property (@(posedge clk) disable iff (rst)
    (adv && head) |-> (cur_branch == '0)); // R2
endmodule

// File: rtl/cdil_deinterleaver.sv
module cdil_deinterleaver #(
  parameter int unsigned DATA_W   = cdil_pkg::BYTE_W,
  parameter int unsigned BRANCHES = 12,
  parameter int unsigned PKT_LEN  = 204
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bypass,
  output logic              out_valid,
  output logic              out_sop,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned UNIT = PKT_LEN / BRANCHES;
  localparam int unsigned BW   = $clog2(BRANCHES);

  logic              adv;
  logic [BW-1:0]     cur_branch;
  logic              head;
  logic [DATA_W-1:0] rd [BRANCHES];
  logic              s1_valid, s1_head;
  logic [BW-1:0]     s1_branch;

  assign adv = in_valid & ~bypass;

  cdil_sequencer #(.BRANCHES(BRANCHES), .PKT_LEN(PKT_LEN)) seq_i (
    .clk(clk), .rst(rst), .adv(adv), .sop(in_sop),
    .cur_branch(cur_branch), .head(head)
  );

  for (genvar j = 0; j < BRANCHES; j++) begin : g_br
    cdil_branch #(
      .DATA_W(DATA_W),
      .DEPTH (cdil_pkg::branch_depth(j, BRANCHES, UNIT))
    ) line_i (
      .clk(clk), .rst(rst),
      .wr_en(adv && (cur_branch == BW'(j))),
      .din(in_data), .rd_data(rd[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_head   <= 1'b0;
      s1_branch <= '0;
    end else begin
      s1_valid  <= adv;
      s1_head   <= head;
      s1_branch <= cur_branch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else if (bypass) begin
      out_valid <= in_valid;
      out_sop   <= in_valid & in_sop;
      out_data  <= in_data;
    end else begin
      out_valid <= s1_valid;
      out_sop   <= s1_valid & s1_head;
      out_data  <= rd[s1_branch];
    end
  end

  // Cycles since reset, saturating; only used to keep $past inside that window.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  AST_LAT_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3 && !bypass && !$past(bypass) && !$past(bypass, 2))
      |-> (out_valid == $past(in_valid, 2))); // R3
  AST_BYP_ECHO: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2 && $past(bypass))
      |-> (out_valid == $past(in_valid) &&
           (!out_valid || out_data == $past(in_data)))); // R4
  AST_SOP_VALID: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid); // R7
endmodule

// File: tb/cdil_deinterleaver_tb.sv
`timescale 1ns/1ps
module cdil_deinterleaver_tb_top;
  localparam int NBR  = 12;
  localparam int PLEN = 204;
  localparam int UNIT = PLEN / NBR;
  localparam int LAT  = (NBR - 1) * UNIT * NBR;
  localparam int NPKT = 30;
  localparam int NTOT = NPKT * PLEN;

  logic       clk = 0, rst = 1;
  logic       in_valid = 0, in_sop = 0, bypass = 0;
  logic [7:0] in_data = 0;
  logic       out_valid, out_sop;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  cdil_deinterleaver dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .bypass(bypass),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data));

  int n_chk = 0, n_fail = 0;
  logic [7:0] orig [NTOT];
  logic [7:0] ilv  [NTOT];
  logic [7:0] il_mem [NBR][(NBR-1)*UNIT];
  int         il_ptr [NBR];

  bit    mode_byp = 0, chk = 0;
  string ntag = "R1";
  int    outcnt = 0;
  logic  vh1 = 0, vh2 = 0, sh1 = 0;
  logic [7:0] dh1 = 0;

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference interleaver: branch j delays by j*UNIT accesses.
  function automatic logic [7:0] interleave(input int i, input logic [7:0] b);
    int j;
    logic [7:0] r;
    j = i % NBR;
    if (j == 0) return b;
    r = il_mem[j][il_ptr[j]];
    il_mem[j][il_ptr[j]] = b;
    il_ptr[j] = (il_ptr[j] + 1) % (j * UNIT);
    return r;
  endfunction

  always @(negedge clk) begin
    if (chk) begin
      check(int'(out_valid), int'(mode_byp ? vh1 : vh2), mode_byp ? "R4" : "R3");
      if (out_sop) check(int'(out_valid), 1, "R7");
    end
    if (out_valid) begin
      if (mode_byp) begin
        if (chk) begin
          check(int'(out_data), int'(dh1), "R4");
          check(int'(out_sop), int'(vh1 & sh1), "R4");
        end
      end else begin
        if (outcnt >= LAT) begin
          check(int'(out_data), int'(orig[outcnt - LAT]), ntag);
          check(int'(out_sop), int'(outcnt % PLEN == 0), (ntag == "R5") ? "R5" : "R2");
        end
        outcnt++;
      end
    end
    vh2 = vh1; vh1 = in_valid; dh1 = in_data; sh1 = in_sop;
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      in_valid = 0; in_sop = 0;
    end
  endtask

  task automatic drive(input logic [7:0] d, input logic s);
    @(posedge clk); #1;
    in_valid = 1; in_sop = s; in_data = d;
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int j = 0; j < NBR; j++) begin
      il_ptr[j] = 0;
      for (int k = 0; k < (NBR-1)*UNIT; k++) il_mem[j][k] = 8'h00;
    end
    for (int i = 0; i < NTOT; i++) begin
      orig[i] = (i % PLEN == 0) ? 8'h47 : 8'($urandom);
      if (i % PLEN == 3) orig[i] = (i / PLEN) % 2 ? 8'hFF : 8'h00;
      ilv[i]  = interleave(i, orig[i]);
    end

    repeat (4) @(posedge clk);
    #1; rst = 0;
    @(negedge clk);
    check(int'(out_valid), 0, "R6");
    check(int'(out_sop), 0, "R6");
    idle(2);
    chk = 1;

    for (int i = 0; i < NTOT; i++) begin
      if (i == 3100) begin
        // Bypass window in mid-stream; state must be left frozen (R5).
        chk = 0; idle(3);
        mode_byp = 1; bypass = 1;
        idle(2); chk = 1;
        for (int b = 0; b < 60; b++) begin
          if (($urandom % 4) == 0) idle(1);
          drive(8'($urandom), ($urandom % 5) == 0);
        end
        drive(8'h00, 1'b0);
        drive(8'hFF, 1'b1);
        idle(2); chk = 0;
        mode_byp = 0; bypass = 0;
        idle(2); chk = 1;
        ntag = "R5";
      end
      if (($urandom % 4) == 0) idle(1 + ($urandom % 2));
      drive(ilv[i], i % PLEN == 0);
    end
    idle(4);
    check(outcnt, NTOT, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule